// File: doc/BRIEF.md
# State-Driven Indicator Blink Controller

This block drives two open-drain indicator pads, a power indicator and a suspend indicator, from the live two-bit sleep-state code of the platform. Each indicator has an eight-bit configuration byte made of four two-bit state-match fields, plus a separate two-bit float field. Every clock the present state code is compared against all five fields. The matching field with the highest priority picks the indicator behaviour: float, steady low, or a 50% duty blink at 1 Hz, 1/2 Hz or 1/4 Hz. If no field matches, the pad floats.

Each indicator has its own small state machine. The states are FLOAT, LOW, BLINK_FAST (1 Hz), BLINK_MID (1/2 Hz) and BLINK_SLOW (1/4 Hz). From any state, the machine moves on each clock edge to the state named by the highest-priority match, or to FLOAT when nothing matches. The order is the float field first, then bits [7:6], [5:4], [3:2] and [1:0]. Reset forces FLOAT. All three blink rates come from one shared prescaler and a three-bit phase counter, so both indicators stay phase-aligned. A common invert input flips the blink phase for both. The surrounding register file is expected to reset the configuration bytes to the package constants 0x9B (power) and 0x98 (suspend).

Top module: `led_state_blinker`

## Requirements
- R1: The state code is 2'b11 for S0, 2'b01 for S3 and 2'b00 for S5. Every field is compared for equality with the present state code.
- R2: When the float field of an indicator equals the state code, that indicator floats (oe=0). This holds whatever its configuration byte says.
- R3: When bits [7:6] are the highest-priority match, the indicator blinks at 1 Hz with 50% duty. oe changes every HALF_PERIOD_CYCLES clocks.
- R4: When bits [5:4] are the highest-priority match, the indicator blinks at 1/2 Hz with 50% duty. oe changes every 2*HALF_PERIOD_CYCLES clocks.
- R5: When bits [3:2] are the highest-priority match, the indicator blinks at 1/4 Hz with 50% duty. oe changes every 4*HALF_PERIOD_CYCLES clocks.
- R6: When bits [1:0] are the only match, the indicator is pulled low steadily (oe=1).
- R7: When several fields match, the priority is float field, then [7:6], then [5:4], then [3:2], then [1:0].
- R8: When no field matches, the indicator floats (oe=0).
- R9: Phase is counted in half-seconds from reset release, and a blinking indicator is pulled low while the selected phase bit XOR blink_inv is 1. With blink_inv=1, the indicator is therefore pulled low in the first period after reset; with blink_inv=0, it floats in that period.
- R10: Both indicators share one time base, so identical configuration and float fields give identical oe on every cycle.
- R11: Open-drain drive: lvl is 0 whenever oe is 1, and lvl is 1 whenever oe is 0.
- R12: A change of the state code or of any field takes effect on oe after exactly one clock edge.
- R13: While rst_n is low, both indicators float, and the blink phase restarts from zero at reset release.
- R14: With the reset bytes 0x9B and 0x98 and float fields of 2'b10, the power indicator is low in S0, blinks at 1/2 Hz in S3 and floats in S5. The suspend indicator floats in S0, blinks at 1/2 Hz in S3 and is low in S5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_code | input | 2 | Present sleep-state code (11 S0, 01 S3, 00 S5) |
| pwr_cfg | input | 8 | Power indicator state-match fields |
| pwr_float_sel | input | 2 | Power indicator float field |
| sus_cfg | input | 8 | Suspend indicator state-match fields |
| sus_float_sel | input | 2 | Suspend indicator float field |
| blink_inv | input | 1 | Inverts the blink phase of both indicators |
| pwr_oe | output | 1 | Power pad pull-down enable |
| pwr_lvl | output | 1 | Power pad driven level |
| sus_oe | output | 1 | Suspend pad pull-down enable |
| sus_lvl | output | 1 | Suspend pad driven level |

## Verification
The bench sets every field to the same state code at once to probe the priority order. A design with a misordered priority encoder would blink at the wrong rate, or pull the pad low when it should float. Blink windows span several full 1/4 Hz periods and are compared cycle by cycle with a phase model counted from reset release. This catches a divider tapped at the wrong bit, a phase that is inverted or not restarted, and an off-by-one prescaler that lets the edges drift. The bench also probes the one-edge latency of a state change, the no-match float case and the reset-byte behaviour in each sleep state. A design that decoded the code 2'b10 as a state, or that floated too late, fails these.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    typedef enum logic [2:0] {
        LM_FLOAT,
        LM_LOW,
        LM_BLINK_FAST,
        LM_BLINK_MID,
        LM_BLINK_SLOW
    } led_mode_e;

    localparam logic [1:0] ST_S0 = 2'b11;
    localparam logic [1:0] ST_S3 = 2'b01;
    localparam logic [1:0] ST_S5 = 2'b00;
    localparam logic [1:0] ST_NONE = 2'b10;

    localparam logic [7:0] PWR_CFG_RST = 8'h9B;
    localparam logic [7:0] SUS_CFG_RST = 8'h98;

    localparam int PHASE_W = 3;

endpackage

// File: rtl/led_timebase.sv
module led_timebase
    import led_blink_pkg::*;
#(
    parameter int HALF_PERIOD_CYCLES = 16_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);
    localparam int CW = (HALF_PERIOD_CYCLES > 2) ? $clog2(HALF_PERIOD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD_CYCLES - 1);

    logic [CW-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            phase   <= '0;
        end else if (pre_cnt == LAST) begin
            pre_cnt <= '0;
            phase   <= phase + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/led_mode_fsm.sv
module led_mode_fsm
    import led_blink_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         state_code,
    input  logic [7:0]         cfg,
    input  logic [1:0]         float_sel,
    input  logic [PHASE_W-1:0] phase,
    input  logic               blink_inv,
    output logic               oe,
    output logic               lvl
);
    led_mode_e mode_q, mode_d;
    logic [4:0] hit;

    // hit[4] float field, hit[3..0] fields [7:6] down to [1:0]
    always_comb begin
        hit[4] = (float_sel == state_code);
        hit[3] = (cfg[7:6] == state_code);
        hit[2] = (cfg[5:4] == state_code);
        hit[1] = (cfg[3:2] == state_code);
        hit[0] = (cfg[1:0] == state_code);
    end

    always_comb begin
        unique casez (hit)
            5'b1????: mode_d = LM_FLOAT;
            5'b01???: mode_d = LM_BLINK_FAST;
            5'b001??: mode_d = LM_BLINK_MID;
            5'b0001?: mode_d = LM_BLINK_SLOW;
            5'b00001: mode_d = LM_LOW;
            5'b00000: mode_d = LM_FLOAT;
            default:  mode_d = LM_FLOAT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= LM_FLOAT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q)
            LM_FLOAT:      oe = 1'b0;
            LM_LOW:        oe = 1'b1;
            LM_BLINK_FAST: oe = phase[0] ^ blink_inv;
            LM_BLINK_MID:  oe = phase[1] ^ blink_inv;
            LM_BLINK_SLOW: oe = phase[2] ^ blink_inv;
            default:       oe = 1'b0;
        endcase
        lvl = oe ? 1'b0 : 1'b1;
    end

endmodule

// File: rtl/led_state_blinker.sv
module led_state_blinker
    import led_blink_pkg::*;
#(
    parameter int HALF_PERIOD_CYCLES = 16_000_000,
    parameter int NUM_LEDS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] state_code,
    input  logic [7:0] pwr_cfg,
    input  logic [1:0] pwr_float_sel,
    input  logic [7:0] sus_cfg,
    input  logic [1:0] sus_float_sel,
    input  logic       blink_inv,
    output logic       pwr_oe,
    output logic       pwr_lvl,
    output logic       sus_oe,
    output logic       sus_lvl
);
    logic [PHASE_W-1:0] phase;
    logic [7:0]         cfg_a   [NUM_LEDS];
    logic [1:0]         fsel_a  [NUM_LEDS];
    logic [NUM_LEDS-1:0] oe_a, lvl_a;

    assign cfg_a[0]  = pwr_cfg;
    assign cfg_a[1]  = sus_cfg;
    assign fsel_a[0] = pwr_float_sel;
    assign fsel_a[1] = sus_float_sel;

    led_timebase #(.HALF_PERIOD_CYCLES(HALF_PERIOD_CYCLES)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        led_mode_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .state_code (state_code),
            .cfg        (cfg_a[i]),
            .float_sel  (fsel_a[i]),
            .phase      (phase),
            .blink_inv  (blink_inv),
            .oe         (oe_a[i]),
            .lvl        (lvl_a[i])
        );
    end

    assign pwr_oe  = oe_a[0];
    assign pwr_lvl = lvl_a[0];
    assign sus_oe  = oe_a[1];
    assign sus_lvl = lvl_a[1];

endmodule

// File: rtl/led_state_blinker_chk.sv
module led_state_blinker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state_code,
    input logic [7:0] pwr_cfg,
    input logic [1:0] pwr_float_sel,
    input logic [7:0] sus_cfg,
    input logic [1:0] sus_float_sel,
    input logic       pwr_oe,
    input logic       pwr_lvl,
    input logic       sus_oe,
    input logic       sus_lvl
);
    a_r2_float_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_float_sel == state_code) |=> !pwr_oe);

    a_r6_low_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cfg[1:0] == state_code && pwr_float_sel != state_code &&
         pwr_cfg[7:6] != state_code && pwr_cfg[5:4] != state_code &&
         pwr_cfg[3:2] != state_code) |=> pwr_oe);

    a_r8_no_match_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (sus_float_sel != state_code && sus_cfg[7:6] != state_code &&
         sus_cfg[5:4] != state_code && sus_cfg[3:2] != state_code &&
         sus_cfg[1:0] != state_code) |=> !sus_oe);

    a_r10_shared_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cfg == sus_cfg && pwr_float_sel == sus_float_sel) |=> (pwr_oe == sus_oe));

    a_r11_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_oe != pwr_lvl) && (sus_oe != sus_lvl));

    a_r13_reset_floats: assert property (@(posedge clk)
        !rst_n |-> (!pwr_oe && !sus_oe));

endmodule

bind led_state_blinker led_state_blinker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_code    (state_code),
    .pwr_cfg       (pwr_cfg),
    .pwr_float_sel (pwr_float_sel),
    .sus_cfg       (sus_cfg),
    .sus_float_sel (sus_float_sel),
    .pwr_oe        (pwr_oe),
    .pwr_lvl       (pwr_lvl),
    .sus_oe        (sus_oe),
    .sus_lvl       (sus_lvl)
);

// File: tb/led_state_blinker_test.sv
`timescale 1ns/1ps
module led_state_blinker_test;
    import led_blink_pkg::*;

    localparam int HALF = 4;
    localparam int K_FLOAT = 0, K_LOW = 1, K_FAST = 2, K_MID = 3, K_SLOW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] state_code = ST_S0;
    logic [7:0] pwr_cfg = 8'h00, sus_cfg = 8'h00;
    logic [1:0] pwr_float_sel = ST_NONE, sus_float_sel = ST_NONE;
    logic blink_inv = 1'b1;
    logic pwr_oe, pwr_lvl, sus_oe, sus_lvl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    led_state_blinker #(.HALF_PERIOD_CYCLES(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .state_code(state_code),
        .pwr_cfg(pwr_cfg), .pwr_float_sel(pwr_float_sel),
        .sus_cfg(sus_cfg), .sus_float_sel(sus_float_sel),
        .blink_inv(blink_inv),
        .pwr_oe(pwr_oe), .pwr_lvl(pwr_lvl), .sus_oe(sus_oe), .sus_lvl(sus_lvl)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic exp_oe(int kind, int c, logic inv);
        int ph;
        ph = (c / HALF) % 8;
        case (kind)
            K_LOW:   return 1'b1;
            K_FAST:  return logic'(ph & 1) ^ inv;
            K_MID:   return logic'((ph >> 1) & 1) ^ inv;
            K_SLOW:  return logic'((ph >> 2) & 1) ^ inv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, logic actual, logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (cycle %0d)", req, actual, expected, cyc);
        end
    endtask

    task automatic apply(logic [1:0] st, logic [7:0] pc, logic [7:0] sc,
                         logic [1:0] pf, logic [1:0] sf, logic inv);
        @(negedge clk);
        state_code = st; pwr_cfg = pc; sus_cfg = sc;
        pwr_float_sel = pf; sus_float_sel = sf; blink_inv = inv;
        @(negedge clk);
    endtask

    // compares both pads with the phase model over n cycles, one check per pad
    task automatic window(string req, int pk, int sk, int n);
        int pbad = 0, sbad = 0;
        logic pa = 0, pe = 0, sa = 0, se = 0;
        for (int i = 0; i < n; i++) begin
            if (pwr_oe !== exp_oe(pk, cyc, blink_inv) || pwr_lvl !== ~pwr_oe) begin
                if (pbad == 0) begin pa = pwr_oe; pe = exp_oe(pk, cyc, blink_inv); end
                pbad++;
            end
            if (sus_oe !== exp_oe(sk, cyc, blink_inv) || sus_lvl !== ~sus_oe) begin
                if (sbad == 0) begin sa = sus_oe; se = exp_oe(sk, cyc, blink_inv); end
                sbad++;
            end
            @(negedge clk);
        end
        check({req, " pwr (R11 level)"}, (pbad == 0) ? pe : pa, pe);
        check({req, " sus (R11 level)"}, (sbad == 0) ? se : sa, se);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R13 pwr floats in reset", pwr_oe, 1'b0);
        check("R13 sus floats in reset", sus_oe, 1'b0);
        check("R11 lvl high in reset", pwr_lvl, 1'b1);
        pwr_cfg = 8'b00_10_10_10; sus_cfg = 8'b10_10_10_00;
        state_code = ST_S5; blink_inv = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 first half lit with inv=1", pwr_oe, 1'b1);
        check("R13 phase restarts at release", pwr_oe, exp_oe(K_FAST, cyc, 1'b1));
    endtask

    task automatic t_defaults();
        apply(ST_S0, PWR_CFG_RST, SUS_CFG_RST, ST_NONE, ST_NONE, 1'b1);
        window("R14 R1 defaults S0", K_LOW, K_FLOAT, 40);
        apply(ST_S3, PWR_CFG_RST, SUS_CFG_RST, ST_NONE, ST_NONE, 1'b1);
        window("R14 R1 defaults S3", K_MID, K_MID, 40);
        apply(ST_S5, PWR_CFG_RST, SUS_CFG_RST, ST_NONE, ST_NONE, 1'b1);
        window("R14 R1 defaults S5", K_FLOAT, K_LOW, 40);
    endtask

    task automatic t_rates();
        apply(ST_S5, 8'b00_10_10_10, 8'b10_10_00_10, ST_NONE, ST_NONE, 1'b1);
        window("R3 fast / R5 slow", K_FAST, K_SLOW, 70);
        apply(ST_S3, 8'b10_01_10_10, 8'b10_10_10_01, ST_NONE, ST_NONE, 1'b1);
        window("R4 mid / R6 low", K_MID, K_LOW, 70);
    endtask

    task automatic t_priority();
        apply(ST_S0, 8'hFF, 8'b10_11_11_11, ST_NONE, ST_NONE, 1'b1);
        window("R7 [7:6] over rest / [5:4] over rest", K_FAST, K_MID, 70);
        apply(ST_S0, 8'b10_10_11_11, 8'hFF, ST_NONE, ST_S0, 1'b1);
        window("R7 [3:2] over [1:0] / R2 float over all", K_SLOW, K_FLOAT, 70);
        apply(ST_S0, 8'hFF, 8'hFF, ST_S0, ST_NONE, 1'b1);
        window("R2 float wins pwr / fast sus", K_FLOAT, K_FAST, 40);
    endtask

    task automatic t_nomatch();
        apply(ST_S3, 8'h00, 8'hAA, ST_S5, ST_NONE, 1'b1);
        window("R8 no match floats", K_FLOAT, K_FLOAT, 40);
    endtask

    task automatic t_invert();
        apply(ST_S5, 8'b00_10_10_10, 8'b10_00_10_10, ST_NONE, ST_NONE, 1'b0);
        window("R9 inverted phase fast/mid", K_FAST, K_MID, 70);
    endtask

    task automatic t_shared();
        int bad = 0;
        apply(ST_S3, 8'b10_10_01_10, 8'b10_10_01_10, ST_NONE, ST_NONE, 1'b1);
        for (int i = 0; i < 80; i++) begin
            if (i == 37) blink_inv = 1'b0;
            if (pwr_oe !== sus_oe) bad++;
            @(negedge clk);
        end
        check("R10 identical config identical oe", logic'(bad != 0), 1'b0);
    endtask

    task automatic t_latency();
        apply(ST_S0, 8'b10_10_10_00, 8'b10_10_10_00, ST_NONE, ST_NONE, 1'b1);
        check("R12 S0 floats before change", pwr_oe, 1'b0);
        state_code = ST_S5;
        #1;
        check("R12 no change before edge", pwr_oe, 1'b0);
        @(negedge clk);
        check("R12 low one edge later", pwr_oe, 1'b1);
        state_code = ST_S0;
        #1;
        check("R12 still low before edge", pwr_oe, 1'b1);
        @(negedge clk);
        check("R12 floats one edge later", pwr_oe, 1'b0);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_rates();
        t_priority();
        t_nomatch();
        t_invert();
        t_shared();
        t_latency();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule